// File: doc/BRIEF.md
# Fractional Reference Clock Generator

This block builds a programmable reference clock from one of up to sixteen slow source clocks. Each source is oversampled in the system clock domain. The rising edges of the selected source drive a divider whose output half-period lasts `div + trim/512` source periods on average, so the output frequency is the source frequency divided by `2 x (div + trim/512)`. A 9-bit accumulator spreads the fractional part: on each accumulator overflow, one half-period is stretched by one source period.

Software programs the block through a small word-addressed register port. The control word sits at offset 0x00, the trim word at 0x10 and a key port at 0x20. Control writes are accepted only right after a two-word unlock key. New divisor and trim values are first staged. They reach the running divider only when a self-clearing switch request is set, and they are applied at a half-period boundary. An activity flag guards the source selector.

Top module: `refclk_gen`

## Requirements
- R1: After reset the control word (0x00) and the trim word (0x10) read 0, and `ref_o` is low.
- R2: A control write takes effect only if the two writes just before it were 32'h5A5AC3C3 and then 32'hA5A53C3C to offset 0x20. A locked control write leaves the control word unchanged. Each unlock admits exactly one control write, and any other write in between cancels the unlock.
- R3: With trim 0 and div > 0, every half-period of `ref_o` lasts div source periods. The source select is bits 3:0, on is bit 15, output enable is bit 12 and div is bits 30:16 of the control word.
- R4: With div > 0 and trim > 0, the half-periods of `ref_o` last div or div+1 source periods. Over any 512 consecutive half-periods the total is `512*div + trim` source periods, and over 512/2^k half-periods it is scaled accordingly when trim is a multiple of 2^k.
- R5: When the running div is 0, `ref_o` follows the selected source level, whatever the trim value.
- R6: Staged div and trim do not change the output until bit 9 (switch request) is written 1 in an unlocked control write. While on, the request transfers them at the next half-period boundary and then bit 9 reads 0.
- R7: Bit 8 (active) reads 1 while on is set, a switch request is pending or a source change is settling. A control write while active leaves the source select unchanged.
- R8: `ref_o` is low whenever on or output enable is 0.
- R9: The trim word holds trim in bits 31:23, and its other bits read 0. Trim writes need no unlock.
- R10: After the source select changes, active stays 1 for SW_CYC cycles (default 4) and then falls if nothing else holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the sources |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_clk_i | input | NSRC | Source clocks, slow relative to clk_i |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| ref_o | output | 1 | Generated reference clock |

## Verification
Integer divisors of 3 and 5 on a period-4 source check half-period lengths cycle by cycle. Trim values of 128, 256 and 511 are checked by summing over a full accumulator pattern. This separates a correct stretch rate from an off-by-one accumulator or a stretch placed on the wrong half. Setting div to 0 with a nonzero trim shows that pass-through overrides the fraction. Changing the staged div without a request, and then with one, shows that the output moves only through the switch path.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int SEL_W   = 4;
  localparam int DIV_W   = 15;
  localparam int TRIM_W  = 9;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_TRIM = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_KEY  = 8'h20;
  localparam int B_ACT    = 8;
  localparam int B_SWR    = 9;
  localparam int B_OE     = 12;
  localparam int B_ON     = 15;
  localparam int DIV_LSB  = 16;
  localparam int TRIM_LSB = 23;
  localparam logic [DATA_W-1:0] KEY_A = 32'h5A5A_C3C3;
  localparam logic [DATA_W-1:0] KEY_B = 32'hA5A5_3C3C;
  typedef enum logic [1:0] {KEY_IDLE, KEY_HALF, KEY_OPEN} key_st_e;
endpackage

// File: rtl/refclk_regs.sv
module refclk_regs
  import refclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              active_i,
  input  logic              load_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              on_o,
  output logic              oe_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [TRIM_W-1:0] trim_o,
  output logic              swreq_o,
  output logic              unlocked_o,
  output logic [DATA_W-1:0] rdata_o
);
  key_st_e key_q;

  assign unlocked_o = (key_q == KEY_OPEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q   <= KEY_IDLE;
      sel_o   <= '0;
      on_o    <= 1'b0;
      oe_o    <= 1'b0;
      div_o   <= '0;
      trim_o  <= '0;
      swreq_o <= 1'b0;
    end else begin
      if (load_i) swreq_o <= 1'b0;
      if (wr_i) begin
        key_q <= KEY_IDLE;
        if (addr_i == OFF_KEY) begin
          if (wdata_i == KEY_A)                            key_q <= KEY_HALF;
          else if (key_q == KEY_HALF && wdata_i == KEY_B)  key_q <= KEY_OPEN;
        end else if (addr_i == OFF_CTRL && key_q == KEY_OPEN) begin
          on_o  <= wdata_i[B_ON];
          oe_o  <= wdata_i[B_OE];
          div_o <= wdata_i[DIV_LSB +: DIV_W];
          if (!active_i)       sel_o   <= wdata_i[SEL_W-1:0];
          if (wdata_i[B_SWR])  swreq_o <= 1'b1;
        end else if (addr_i == OFF_TRIM) begin
          trim_o <= wdata_i[TRIM_LSB +: TRIM_W];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CTRL: begin
        rdata_o[SEL_W-1:0]            = sel_o;
        rdata_o[B_ACT]                = active_i;
        rdata_o[B_SWR]                = swreq_o;
        rdata_o[B_OE]                 = oe_o;
        rdata_o[B_ON]                 = on_o;
        rdata_o[DIV_LSB +: DIV_W]     = div_o;
      end
      OFF_TRIM: rdata_o[TRIM_LSB +: TRIM_W] = trim_o;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/refclk_srcsel.sv
module refclk_srcsel
  import refclk_pkg::*;
#(
  parameter int NSRC   = 16,
  parameter int SW_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  src_clk_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             lvl_o,
  output logic             edge_o,
  output logic             busy_o
);
  localparam int NPAD = 1 << SEL_W;
  localparam int CW   = $clog2(SW_CYC + 1);

  logic [NSRC-1:0]  smp_q;
  logic [NPAD-1:0]  smp_pad;
  logic             lvl_q;
  logic [SEL_W-1:0] sel_prev_q;
  logic [CW-1:0]    cnt_q;
  logic             moved;

  always_comb begin
    smp_pad = '0;
    smp_pad[NSRC-1:0] = smp_q;
  end

  assign lvl_o  = smp_pad[sel_i];
  assign moved  = (sel_i != sel_prev_q);
  assign busy_o = moved || (cnt_q != '0);
  // edges are masked while the mux settles on a new source
  assign edge_o = lvl_o && !lvl_q && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q      <= '0;
      lvl_q      <= 1'b0;
      sel_prev_q <= '0;
      cnt_q      <= '0;
    end else begin
      smp_q <= src_clk_i;
      lvl_q <= lvl_o;
      if (moved) begin
        sel_prev_q <= sel_i;
        cnt_q      <= CW'(SW_CYC - 1);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/refclk_fracdiv.sv
module refclk_fracdiv
  import refclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              oe_i,
  input  logic              edge_i,
  input  logic              lvl_i,
  input  logic              swreq_i,
  input  logic [DIV_W-1:0]  div_stg_i,
  input  logic [TRIM_W-1:0] trim_stg_i,
  output logic              load_o,
  output logic [DIV_W-1:0]  run_div_o,
  output logic              ref_o
);
  logic [TRIM_W-1:0] trim_run_q, acc_q;
  logic              ext_q, out_q, bnd;
  logic [DIV_W:0]    cnt_q, lim;

  assign lim    = {1'b0, run_div_o} + {{DIV_W{1'b0}}, ext_q};
  assign bnd    = en_i && edge_i && ((run_div_o == '0) || ((cnt_q + 1'b1) == lim));
  assign load_o = bnd && swreq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_div_o  <= '0;
      trim_run_q <= '0;
      acc_q      <= '0;
      ext_q      <= 1'b0;
      cnt_q      <= '0;
      out_q      <= 1'b0;
      ref_o      <= 1'b0;
    end else begin
      ref_o <= en_i && oe_i && out_q;
      if (!en_i) begin
        acc_q <= '0;
        ext_q <= 1'b0;
        cnt_q <= '0;
        out_q <= 1'b0;
      end else begin
        if (bnd) begin
          cnt_q <= '0;
          if (load_o) begin
            run_div_o  <= div_stg_i;
            trim_run_q <= trim_stg_i;
            acc_q      <= '0;
            ext_q      <= 1'b0;
          end else begin
            // overflow of the fraction stretches the next half-period
            {ext_q, acc_q} <= {1'b0, acc_q} + {1'b0, trim_run_q};
          end
        end else if (edge_i) begin
          cnt_q <= cnt_q + 1'b1;
        end
        out_q <= (run_div_o == '0) ? lvl_i : (bnd ? !out_q : out_q);
      end
    end
  end
endmodule

// File: rtl/refclk_gen.sv
module refclk_gen
  import refclk_pkg::*;
#(
  parameter int NSRC   = 16,
  parameter int SW_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_clk_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ref_o
);
  logic [SEL_W-1:0]  sel_q;
  logic              on_q, oe_q, swreq_q, unlocked, active, busy, lvl, src_edge, load;
  logic [DIV_W-1:0]  div_stg, run_div;
  logic [TRIM_W-1:0] trim_stg;

  assign active = on_q || swreq_q || busy;

  refclk_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .active_i(active), .load_i(load),
    .sel_o(sel_q), .on_o(on_q), .oe_o(oe_q), .div_o(div_stg), .trim_o(trim_stg),
    .swreq_o(swreq_q), .unlocked_o(unlocked), .rdata_o
  );

  refclk_srcsel #(.NSRC(NSRC), .SW_CYC(SW_CYC)) u_src (
    .clk_i, .rst_ni, .src_clk_i, .sel_i(sel_q),
    .lvl_o(lvl), .edge_o(src_edge), .busy_o(busy)
  );

  refclk_fracdiv u_div (
    .clk_i, .rst_ni, .en_i(on_q), .oe_i(oe_q), .edge_i(src_edge), .lvl_i(lvl),
    .swreq_i(swreq_q), .div_stg_i(div_stg), .trim_stg_i(trim_stg),
    .load_o(load), .run_div_o(run_div), .ref_o
  );
endmodule

// File: rtl/refclk_gen_chk.sv
module refclk_gen_chk
  import refclk_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              unlocked,
  input logic              on_q,
  input logic              oe_q,
  input logic [DIV_W-1:0]  div_stg,
  input logic              active,
  input logic [SEL_W-1:0]  sel_q,
  input logic              load,
  input logic              swreq_q,
  input logic [DIV_W-1:0]  run_div,
  input logic              ref_o
);
  AST_LOCKED_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_CTRL && !unlocked) |=> ($stable(on_q) && $stable(oe_q) && $stable(div_stg))); // R2
  AST_SEL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |=> $stable(sel_q)); // R7
  AST_SWREQ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !(wr_i && addr_i == OFF_CTRL)) |=> !swreq_q); // R6
  AST_RUN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(run_div)); // R6
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on_q || !oe_q) |=> !ref_o); // R8
endmodule

bind refclk_gen refclk_gen_chk u_chk (
  .clk_i, .rst_ni, .wr_i, .addr_i, .unlocked, .on_q, .oe_q, .div_stg,
  .active, .sel_q, .load, .swreq_q, .run_div, .ref_o
);

// File: tb/refclk_gen_test.sv
module refclk_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  int          scnt [16] = '{default: 0};
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ref_clk;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  // source k toggles every k+1 clock cycles
  always @(posedge clk)
    for (int k = 0; k < 16; k++)
      if (scnt[k] == k) begin scnt[k] <= 0; src[k] <= ~src[k]; end
      else scnt[k] <= scnt[k] + 1;

  refclk_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .src_clk_i(src), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ref_o(ref_clk)
  );

  function automatic logic [31:0] cw(int sel, bit on, bit oe, bit swr, int dv);
    return (32'(dv) << 16) | (32'(on) << 15) | (32'(oe) << 12) | (32'(swr) << 9) | 32'(sel);
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic ctrl_wr(logic [31:0] d);
    wr_reg(8'h20, 32'h5A5A_C3C3);
    wr_reg(8'h20, 32'hA5A5_3C3C);
    wr_reg(8'h00, d);
  endtask

  task automatic next_flip(output int n);
    logic prev;
    prev = ref_clk; n = 0;
    do begin @(negedge clk); n++; end while (ref_clk == prev && n < 20000);
  endtask

  task automatic sum_flips(int k, output int s);
    int n;
    s = 0;
    next_flip(n); next_flip(n); next_flip(n);
    for (int i = 0; i < k; i++) begin next_flip(n); s += n; end
  endtask

  task automatic wait_load(string req);
    logic [31:0] d;
    int i;
    for (i = 0; i < 5000; i++) begin
      rd_reg(8'h00, d);
      if (!d[9]) break;
    end
    check(req, i < 5000, 1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd_reg(8'h00, d); check("R1 ctrl", d, 0);
    rd_reg(8'h10, d); check("R1 trim", d, 0);
    check("R1 ref_o", ref_clk, 0);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    wr_reg(8'h00, cw(0, 1, 1, 0, 7));
    rd_reg(8'h00, d); check("R2 locked write", d, 0);
    ctrl_wr(cw(0, 0, 1, 0, 0));
    rd_reg(8'h00, d); check("R2 unlocked write", d, 32'h1000);
    wr_reg(8'h00, cw(0, 0, 0, 0, 9));
    rd_reg(8'h00, d); check("R2 unlock consumed", d, 32'h1000);
    wr_reg(8'h20, 32'h5A5A_C3C3); wr_reg(8'h10, 0); wr_reg(8'h20, 32'hA5A5_3C3C);
    wr_reg(8'h00, cw(0, 0, 0, 0, 0));
    rd_reg(8'h00, d); check("R2 interrupted key", d, 32'h1000);
  endtask

  task automatic t_trim_reg;
    logic [31:0] d;
    wr_reg(8'h10, 32'hFFFF_FFFF);
    rd_reg(8'h10, d); check("R9 trim field", d, 32'hFF80_0000);
    wr_reg(8'h10, 0);
  endtask

  task automatic t_sel;
    logic [31:0] d;
    ctrl_wr(cw(1, 0, 0, 0, 0));
    rd_reg(8'h00, d); check("R10 active after sel change", d[8], 1);
    repeat (6) @(negedge clk);
    rd_reg(8'h00, d); check("R10 active falls", d[8], 0);
    check("R10 sel taken", d[3:0], 1);
  endtask

  task automatic t_int_div;
    logic [31:0] d;
    int s, n;
    ctrl_wr(cw(1, 1, 1, 1, 3));
    wait_load("R6 request clears");
    sum_flips(1, n); check("R3 half-period div3", n, 12);
    sum_flips(4, s); check("R3 four halves div3", s, 48);
    ctrl_wr(cw(3, 1, 1, 0, 5));
    rd_reg(8'h00, d); check("R7 sel ignored while active", d[3:0], 1);
    check("R7 active while on", d[8], 1);
    sum_flips(2, s); check("R6 staged div not applied", s, 24);
    ctrl_wr(cw(1, 1, 1, 1, 5));
    wait_load("R6 request clears div5");
    sum_flips(2, s); check("R6 new div applied", s, 40);
  endtask

  task automatic t_frac;
    int s;
    wr_reg(8'h10, 32'(256) << 23);
    ctrl_wr(cw(1, 1, 1, 1, 2));
    wait_load("R4 load 256");
    sum_flips(2, s); check("R4 trim256 pair", s, 20);
    sum_flips(4, s); check("R4 trim256 quad", s, 40);
    wr_reg(8'h10, 32'(128) << 23);
    ctrl_wr(cw(1, 1, 1, 1, 2));
    wait_load("R4 load 128");
    sum_flips(4, s); check("R4 trim128 quad", s, 36);
    wr_reg(8'h10, 32'(511) << 23);
    ctrl_wr(cw(1, 1, 1, 1, 1));
    wait_load("R4 load 511");
    sum_flips(512, s); check("R4 trim511 full cycle", s, 4092);
  endtask

  task automatic t_pass;
    int n;
    wr_reg(8'h10, 32'(256) << 23);
    ctrl_wr(cw(1, 1, 1, 1, 0));
    wait_load("R5 load");
    sum_flips(1, n); check("R5 passthrough half", n, 2);
    sum_flips(1, n); check("R5 passthrough half again", n, 2);
  endtask

  task automatic t_gate;
    int hi;
    ctrl_wr(cw(1, 1, 0, 0, 0));
    hi = 0;
    repeat (3) @(negedge clk);
    repeat (40) begin @(negedge clk); if (ref_clk) hi++; end
    check("R8 oe low keeps output low", hi, 0);
    ctrl_wr(cw(1, 0, 1, 0, 0));
    hi = 0;
    repeat (3) @(negedge clk);
    repeat (40) begin @(negedge clk); if (ref_clk) hi++; end
    check("R8 off keeps output low", hi, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_lock;
    t_trim_reg;
    t_sel;
    t_int_div;
    t_frac;
    t_pass;
    t_gate;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule